// File: doc/BRIEF.md
# Debug Hart Handshake Mailbox

This block is the small memory-mapped mailbox that sits between a debug module and the harts that are parked in a debug ROM loop. A parked hart polls a flag byte of its own and announces what it is doing by storing to a few side-effect addresses. The mailbox turns those stores into per-hart state. It also serves the flag bytes and a patchable jump instruction that tells the hart where to go next.

The debugger side uses a single-cycle command port. A go command points one halted hart at the abstract command area or the program buffer. A resume command releases any set of halted harts. A clear command drops the error latch. The block answers with a busy pulse when it refuses a go, a done pulse when the hart that took a go has come back to the ROM, per-hart resume acknowledges, a sticky error flag, and the halted status of every hart.

Top module: `dbg_hs_mailbox`

## Requirements
- R1: After reset every GO and RESUME flag is clear, no hart is marked halted, `err`, `cmd_busy`, `go_done` and `resume_ack` are 0, and `redirect_word` holds the jump to the resume path (0x5040006F with default addresses).
- R2: A read at 0x400 + h returns hart h's flag byte in `hb_rdata[7:0]`, with GO at bit 0 and RESUME at bit 1 and all upper bits zero. Offsets 0x400 + h with h >= NHARTS read as zero. A read at 0x300 returns the redirect word. Any other read returns zero.
- R3: A store of value h to 0x100 (halted) marks hart h halted. A value of NHARTS or more changes no state.
- R4: A go command (op 1) is accepted only if the target hart is halted and no go is in progress: no armed GO, no set GO flag, and no hart working on a go. Otherwise `cmd_busy` pulses for one cycle and nothing else changes. At most one GO flag is ever set.
- R5: An accepted go writes the redirect word at the accepting edge. The GO flag rises one edge later. Destination 0 jumps to the abstract area (0x0400006F), destination 1 to the program buffer (0x0600006F), and destinations 2 and 3 to the resume path (0x5040006F). Each word is an x0 jump relative to 0x300.
- R6: Any store to 0x104 (going) clears the pending GO flag.
- R7: After a going store, a halted store carrying the id of the hart that took the go raises `go_done` for exactly one cycle. Halted stores from other harts do not raise it.
- R8: A resume command (op 2) sets RESUME only for harts in `cmd_mask` that are halted.
- R9: A store of value h to 0x108 (resuming) clears hart h's RESUME flag and marks it running. If that flag was set, `resume_ack[h]` pulses for one cycle.
- R10: Any store to 0x10C (exception) sets `err`. Only a clear command (op 3) drops it. If an exception store and a clear arrive in the same cycle, `err` stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hb_valid | input | 1 | Hart bus access valid |
| hb_we | input | 1 | Hart bus access is a store |
| hb_addr | input | 12 | Hart bus byte address |
| hb_wdata | input | 32 | Store data (hart id for halted/resuming) |
| hb_rdata | output | 32 | Read data, combinational from state |
| cmd_valid | input | 1 | Debugger command valid |
| cmd_op | input | 2 | 1 go, 2 resume, 3 clear error, 0 none |
| cmd_hart | input | 2 | Target hart of a go |
| cmd_dest | input | 2 | Go destination: 0 abstract, 1 program buffer, else resume |
| cmd_mask | input | 4 | Harts named by a resume |
| cmd_busy | output | 1 | One-cycle pulse: go refused |
| go_done | output | 1 | One-cycle pulse: go hart back in the ROM |
| resume_ack | output | 4 | One-cycle pulse per hart that acknowledged a resume |
| halted | output | 4 | Per-hart halted status |
| err | output | 1 | Sticky exception latch |
| redirect_word | output | 32 | Current redirect jump instruction |

## Verification
A corrupted flag vector shows up as a wrong byte on the very next flag read. Because parked harts poll without a break, such a fault becomes visible within a few cycles. A lost or stuck in-progress marker for the go shows up either as a `cmd_busy` on a legal go or as a missing `cmd_busy` on an illegal one. It can also show up as a `go_done` that never arrives or that comes from the wrong hart. If the redirect word or the arm stage is wrong, the problem is visible in the cycle after acceptance: either the jump word is wrong, or the GO bit appears too early or not at all.

// File: rtl/dbg_hs_pkg.sv
package dbg_hs_pkg;
    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_GO     = 2'd1,
        OP_RESUME = 2'd2,
        OP_CLRERR = 2'd3
    } cmd_op_e;

    typedef enum logic [1:0] {
        DEST_ABSTRACT = 2'd0,
        DEST_PROGBUF  = 2'd1,
        DEST_RESUME   = 2'd2
    } dest_e;

    // Bit positions inside a flag byte; the ROM loop tests these.
    localparam int FLAG_GO_BIT  = 0;
    localparam int FLAG_RES_BIT = 1;

    // Build "jal x0, off".
    function automatic logic [31:0] jal_x0(input int off);
        logic [31:0] o;
        o = off;
        return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6F};
    endfunction
endpackage

// File: rtl/dbg_hs_decode.sv
module dbg_hs_decode #(
    parameter int AW          = 12,
    parameter int NHARTS      = 4,
    parameter int HALTED_ADDR = 'h100,
    parameter int GOING_ADDR  = 'h104,
    parameter int RESUME_ADDR = 'h108,
    parameter int EXC_ADDR    = 'h10C,
    parameter int REDIR_ADDR  = 'h300,
    parameter int FLAG_BASE   = 'h400,
    localparam int HW = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic          valid,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic          st_halted,
    output logic          st_going,
    output logic          st_resuming,
    output logic          st_exc,
    output logic          id_ok,
    output logic [HW-1:0] id,
    output logic          rd_flag,
    output logic [HW-1:0] flag_idx,
    output logic          rd_redir
);
    logic wr, rd, in_window;

    always_comb begin
        wr          = valid && we;
        rd          = valid && !we;
        st_halted   = wr && (addr == AW'(HALTED_ADDR));
        st_going    = wr && (addr == AW'(GOING_ADDR));
        st_resuming = wr && (addr == AW'(RESUME_ADDR));
        st_exc      = wr && (addr == AW'(EXC_ADDR));
        id_ok       = (wdata < 32'(NHARTS));
        id          = wdata[HW-1:0];
        in_window   = addr[AW-1:8] == (AW-8)'(FLAG_BASE >> 8);
        rd_flag     = rd && in_window && (32'(addr[7:0]) < 32'(NHARTS));
        flag_idx    = addr[HW-1:0];
        rd_redir    = rd && (addr == AW'(REDIR_ADDR));
    end
endmodule

// File: rtl/dbg_hs_redirect.sv
module dbg_hs_redirect
    import dbg_hs_pkg::*;
#(
    parameter int REDIR_ADDR = 'h300,
    parameter int ABS_ADDR   = 'h340,
    parameter int PBUF_ADDR  = 'h360,
    parameter int RES_ADDR   = 'h804
) (
    input  logic [1:0]  dest,
    output logic [31:0] word
);
    localparam logic [31:0] JAL_ABS  = jal_x0(ABS_ADDR  - REDIR_ADDR);
    localparam logic [31:0] JAL_PBUF = jal_x0(PBUF_ADDR - REDIR_ADDR);
    localparam logic [31:0] JAL_RES  = jal_x0(RES_ADDR  - REDIR_ADDR);

    always_comb begin
        case (dest)
            DEST_ABSTRACT: word = JAL_ABS;
            DEST_PROGBUF:  word = JAL_PBUF;
            default:       word = JAL_RES;
        endcase
    end
endmodule

// File: rtl/dbg_hs_mailbox.sv
module dbg_hs_mailbox
    import dbg_hs_pkg::*;
#(
    parameter int NHARTS = 4,
    parameter int AW     = 12,
    localparam int HW = (NHARTS > 1) ? $clog2(NHARTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hb_valid,
    input  logic              hb_we,
    input  logic [AW-1:0]     hb_addr,
    input  logic [31:0]       hb_wdata,
    output logic [31:0]       hb_rdata,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [HW-1:0]     cmd_hart,
    input  logic [1:0]        cmd_dest,
    input  logic [NHARTS-1:0] cmd_mask,
    output logic              cmd_busy,
    output logic              go_done,
    output logic [NHARTS-1:0] resume_ack,
    output logic [NHARTS-1:0] halted,
    output logic              err,
    output logic [31:0]       redirect_word
);
    typedef struct packed {
        logic [NHARTS-1:0] go;
        logic [NHARTS-1:0] res;
        logic [NHARTS-1:0] halted;
        logic              arm;
        logic              run;
        logic [HW-1:0]     go_hart;
        logic [1:0]        dest;
        logic              err;
        logic              busy;
        logic              done;
        logic [NHARTS-1:0] rack;
    } state_t;

    state_t s_d, s_q;

    logic          st_halted, st_going, st_resuming, st_exc, id_ok;
    logic          rd_flag, rd_redir;
    logic [HW-1:0] id, flag_idx;
    logic [7:0]    flag_byte;

    dbg_hs_decode #(.AW(AW), .NHARTS(NHARTS)) u_dec (
        .valid(hb_valid), .we(hb_we), .addr(hb_addr), .wdata(hb_wdata),
        .st_halted(st_halted), .st_going(st_going), .st_resuming(st_resuming),
        .st_exc(st_exc), .id_ok(id_ok), .id(id), .rd_flag(rd_flag),
        .flag_idx(flag_idx), .rd_redir(rd_redir)
    );

    dbg_hs_redirect u_redir (.dest(s_q.dest), .word(redirect_word));

    always_comb begin
        s_d      = s_q;
        s_d.busy = 1'b0;
        s_d.done = 1'b0;
        s_d.rack = '0;

        // Second half of an accepted go: raise the flag now that the word is set.
        if (s_q.arm) begin
            s_d.go[s_q.go_hart] = 1'b1;
            s_d.arm             = 1'b0;
        end

        if (st_halted && id_ok) begin
            s_d.halted[id] = 1'b1;
            if (s_q.run && s_q.go_hart == id) begin
                s_d.done = 1'b1;
                s_d.run  = 1'b0;
            end
        end

        if (st_going) begin
            if (|s_q.go) s_d.run = 1'b1;
            s_d.go = '0;
        end

        if (st_resuming && id_ok) begin
            if (s_q.res[id]) s_d.rack[id] = 1'b1;
            s_d.res[id]    = 1'b0;
            s_d.halted[id] = 1'b0;
        end

        if (cmd_valid) begin
            case (cmd_op)
                OP_GO: begin
                    if (32'(cmd_hart) < 32'(NHARTS) && s_q.halted[cmd_hart] &&
                        !s_q.arm && !(|s_q.go) && !s_q.run) begin
                        s_d.dest    = cmd_dest;
                        s_d.go_hart = cmd_hart;
                        s_d.arm     = 1'b1;
                    end else begin
                        s_d.busy = 1'b1;
                    end
                end
                OP_RESUME: s_d.res = s_d.res | (cmd_mask & s_d.halted);
                OP_CLRERR: s_d.err = 1'b0;
                default: ;
            endcase
        end

        if (st_exc) s_d.err = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.dest <= DEST_RESUME;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        flag_byte                = '0;
        flag_byte[FLAG_GO_BIT]  = s_q.go[flag_idx];
        flag_byte[FLAG_RES_BIT] = s_q.res[flag_idx];
        if (rd_flag)       hb_rdata = {24'd0, flag_byte};
        else if (rd_redir) hb_rdata = redirect_word;
        else               hb_rdata = '0;
    end

    assign cmd_busy   = s_q.busy;
    assign go_done    = s_q.done;
    assign resume_ack = s_q.rack;
    assign halted     = s_q.halted;
    assign err        = s_q.err;

    // R4: a single hart may hold GO
    assert_go_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.go));

    // R5: redirect word settled in the cycle before GO rises
    assert_redirect_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|s_q.go) |-> $stable(redirect_word));

    // R7: done only when the go hart is back in the halted state
    assert_done_halted_R7: assert property (@(posedge clk) disable iff (!rst_n)
        go_done |-> halted[s_q.go_hart]);

    // R10: error drops only on an explicit clear
    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> $past(cmd_valid && cmd_op == OP_CLRERR));

    for (genvar h = 0; h < NHARTS; h++) begin : g_hart_chk
        // R8: a resume flag appears only on a halted hart
        assert_resume_halted_R8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(s_q.res[h]) |-> halted[h]);
        // R9: an acknowledged hart is no longer halted
        assert_ack_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
            resume_ack[h] |-> !halted[h]);
    end
endmodule

// File: tb/dbg_hs_mailbox_tb.sv
`timescale 1ns/1ps
module dbg_hs_mailbox_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hb_valid = 0, hb_we = 0;
    logic [11:0] hb_addr = '0;
    logic [31:0] hb_wdata = '0;
    logic [31:0] hb_rdata;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_op = '0, cmd_hart = '0, cmd_dest = '0;
    logic [3:0]  cmd_mask = '0;
    logic        cmd_busy, go_done, err;
    logic [3:0]  resume_ack, halted;
    logic [31:0] redirect_word;

    int checks = 0, fails = 0;
    bit finished = 0;

    localparam logic [31:0] J_ABS = 32'h0400006F;
    localparam logic [31:0] J_PB  = 32'h0600006F;
    localparam logic [31:0] J_RES = 32'h5040006F;

    always #2 clk = ~clk;

    dbg_hs_mailbox dut_i (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        hb_valid = 1; hb_we = 1; hb_addr = a; hb_wdata = d;
        @(negedge clk);
        hb_valid = 0; hb_we = 0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        hb_valid = 1; hb_we = 0; hb_addr = a;
        #0.5 d = hb_rdata;
        hb_valid = 0;
    endtask

    task automatic cmd(logic [1:0] op, logic [1:0] h, logic [1:0] ds, logic [3:0] m);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_hart = h; cmd_dest = ds; cmd_mask = m;
        @(negedge clk);
        cmd_valid = 0; cmd_op = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 halted", 32'(halted), 0);
        chk("R1 err", 32'(err), 0);
        chk("R1 pulses", {go_done, cmd_busy, resume_ack}, 0);
        chk("R1 redirect", redirect_word, J_RES);
        rd(12'h401, d); chk("R1 flag", d, 0);
        rd(12'h300, d); chk("R2 redirect read", d, J_RES);
        rd(12'h200, d); chk("R2 other read", d, 0);
    endtask

    task automatic t_halted();
        store(12'h100, 1);
        store(12'h100, 2);
        chk("R3 halted set", 32'(halted), 32'h6);
        store(12'h100, 5);
        chk("R3 bad id ignored", 32'(halted), 32'h6);
    endtask

    task automatic t_go();
        logic [31:0] d;
        cmd(2'd1, 2'd0, 2'd1, 0);
        chk("R4 busy not halted", 32'(cmd_busy), 1);
        chk("R4 no redirect change", redirect_word, J_RES);
        cmd(2'd1, 2'd1, 2'd1, 0);
        chk("R4 accept", 32'(cmd_busy), 0);
        chk("R5 redirect progbuf", redirect_word, J_PB);
        rd(12'h401, d); chk("R5 GO not yet", d, 0);
        @(negedge clk);
        rd(12'h401, d); chk("R2 GO bit0", d, 32'h1);
        cmd(2'd1, 2'd2, 2'd0, 0);
        chk("R4 busy pending", 32'(cmd_busy), 1);
        rd(12'h402, d); chk("R4 single GO", d, 0);
        store(12'h104, 0);
        rd(12'h401, d); chk("R6 GO cleared", d, 0);
        cmd(2'd1, 2'd2, 2'd0, 0);
        chk("R4 busy while running", 32'(cmd_busy), 1);
        store(12'h100, 2);
        chk("R7 no done other hart", 32'(go_done), 0);
        store(12'h100, 1);
        chk("R7 done", 32'(go_done), 1);
        @(negedge clk);
        chk("R7 done one cycle", 32'(go_done), 0);
        cmd(2'd1, 2'd2, 2'd0, 0);
        chk("R5 redirect abstract", redirect_word, J_ABS);
        store(12'h104, 0);
        store(12'h100, 2);
        chk("R7 done abstract", 32'(go_done), 1);
    endtask

    task automatic t_resume();
        logic [31:0] d;
        cmd(2'd2, 0, 0, 4'hF);
        rd(12'h401, d); chk("R8 hart1 RESUME bit1", d, 32'h2);
        rd(12'h402, d); chk("R8 hart2 RESUME", d, 32'h2);
        rd(12'h400, d); chk("R8 hart0 not halted", d, 0);
        rd(12'h404, d); chk("R2 unmapped flag", d, 0);
        store(12'h108, 1);
        chk("R9 ack", 32'(resume_ack), 32'h2);
        chk("R9 running", 32'(halted), 32'h4);
        rd(12'h401, d); chk("R9 flag cleared", d, 0);
        @(negedge clk);
        chk("R9 ack one cycle", 32'(resume_ack), 0);
        store(12'h108, 1);
        chk("R9 no ack without flag", 32'(resume_ack), 0);
    endtask

    task automatic t_err();
        store(12'h10C, 0);
        chk("R10 err set", 32'(err), 1);
        cmd(2'd2, 0, 0, 4'h0);
        chk("R10 err sticky", 32'(err), 1);
        cmd(2'd3, 0, 0, 0);
        chk("R10 err cleared", 32'(err), 0);
        @(negedge clk);
        hb_valid = 1; hb_we = 1; hb_addr = 12'h10C; cmd_valid = 1; cmd_op = 2'd3;
        @(negedge clk);
        hb_valid = 0; hb_we = 0; cmd_valid = 0; cmd_op = 0;
        chk("R10 set wins", 32'(err), 1);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_halted();
        t_go();
        t_resume();
        t_err();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule